// File: doc/BRIEF.md
# Page-Write Buffer and Program Timer

This block is the write side of a byte-wide nonvolatile memory model with a 15-bit address. The host drives active-low chip-select, output-enable and write-enable lines. The block samples them on a clock, so each clock cycle is one bus access. The first accepted write opens a load window and fixes the page, which is taken from address bits 14 to 6. Later writes to the same page fill any of the 64 byte slots, in any order. A slot may be written more than once. Each loaded slot is flagged in a 64-bit mask.

The window closes when no write has been accepted for `LOAD_CYCLES` clock cycles in a row. A program phase of `PROG_CYCLES` cycles then follows, and `busy` is high for all of it. In the last cycle of that phase, only the flagged slots are copied into a behavioural storage array. The mask and the poll toggle are cleared in the same cycle. From the first accepted write until the program phase ends, reads return a status byte instead of array data.

The storage array holds `STORE_PAGES` pages, 16 by default. The page number indexes it modulo `STORE_PAGES`. All bytes read 8'hFF after reset.

Top module: `page_program_engine`

## Requirements
- R1: A cycle with ceN=0, weN=0 and oeN=1 is a write strobe. Any other combination writes nothing. In the idle state a write strobe is accepted: it latches the page (addr[14:6]), stores wrData in slot addr[5:0] and marks that slot as loaded.
- R2: During the load window, accepted writes may come in any slot order. When a slot is written more than once, the last value written is the one committed.
- R3: During the load window, a write strobe whose addr[14:6] differs from the latched page is ignored. It loads nothing and does not restart the timeout.
- R4: Each accepted write restarts the load timeout. `busy` rises on the clock edge that completes `LOAD_CYCLES` consecutive cycles without an accepted write. It stays high for exactly `PROG_CYCLES` cycles.
- R5: When `busy` falls, every loaded slot has been written to storage at index (page mod `STORE_PAGES`)*64 + slot. Slots that were not loaded keep their old contents. Storage reads 8'hFF after reset.
- R6: rdDrive is 1 exactly in cycles with ceN=0, oeN=0 and weN=1. Whenever rdDrive is 0, rdData is 8'h00.
- R7: From the first accepted write until `busy` falls, a read returns a status byte instead of array data. In that byte, bit 7 is the complement of bit 7 of the last accepted byte and bits 5:0 are 0.
- R8: Bit 6 of the status byte is 0 on the first status read of a write cycle. It inverts after each status read cycle.
- R9: Write strobes while `busy` is high are ignored. They change neither the committed data, the status bit 7, nor the program timing.
- R10: When `busy` is low and no window is open, reads return the stored byte, and a new write opens a new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | 15 | Byte address: page in bits 14:6, slot in bits 5:0 |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data or status byte; 0 when not driven |
| rdDrive | output | 1 | High when the block drives rdData onto the bus |
| busy | output | 1 | Internal program phase in progress |

## Verification
The hardest cases to reach are the timeout boundary and strobes that land during the program phase. The stimulus leaves gaps of exactly `LOAD_CYCLES-1` idle cycles, which keep the window open. It also sends foreign-page writes mid-window, which must not restart the timer. It waits for `busy` and then issues writes that must leave the data and the timing unchanged. A full page loaded in descending slot order, plus a write to a page that aliases to a lower page of the array, cover the mask and the indexing at their edges. A behavioural model compares rdData, rdDrive and busy on every cycle, so every status read is also checked for its toggle bit.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_PROG = 2'd2
  } phase_t;

  typedef struct packed {
    logic latchPage;
    logic loadByte;
    logic commitPage;
    logic polling;
    logic readAcc;
  } ctrlStrobes_t;
endpackage

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
#(
  parameter int LOAD_CYCLES = 4,
  parameter int PROG_CYCLES = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ceN,
  input  logic         oeN,
  input  logic         weN,
  input  logic         pageMatch,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         inLoad
);
  localparam int IDLE_W = $clog2(LOAD_CYCLES + 1);
  localparam int PROG_W = $clog2(PROG_CYCLES + 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(LOAD_CYCLES - 1);
  localparam logic [PROG_W-1:0] PROG_LAST = PROG_W'(PROG_CYCLES - 1);

  phase_t phase;
  logic [IDLE_W-1:0] idleCnt;
  logic [PROG_W-1:0] progCnt;
  logic wrStrobe, rdStrobe, acceptWr;

  assign wrStrobe = !ceN && !weN && oeN;
  assign rdStrobe = !ceN && !oeN && weN;
  assign acceptWr = wrStrobe && ((phase == PH_IDLE) || (phase == PH_LOAD && pageMatch));

  always_comb begin
    strobes            = '0;
    strobes.latchPage  = wrStrobe && (phase == PH_IDLE);
    strobes.loadByte   = acceptWr;
    strobes.commitPage = (phase == PH_PROG) && (progCnt == PROG_LAST);
    strobes.polling    = (phase != PH_IDLE);
    strobes.readAcc    = rdStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      idleCnt <= '0;
      progCnt <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (acceptWr) begin
            phase   <= PH_LOAD;
            idleCnt <= '0;
          end
        end
        PH_LOAD: begin
          if (acceptWr) begin
            idleCnt <= '0;
          end else if (idleCnt == IDLE_LAST) begin
            phase   <= PH_PROG;
            progCnt <= '0;
          end else begin
            idleCnt <= idleCnt + 1'b1;
          end
        end
        PH_PROG: begin
          if (progCnt == PROG_LAST) begin
            phase   <= PH_IDLE;
            idleCnt <= '0;
            progCnt <= '0;
          end else begin
            progCnt <= progCnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy   = (phase == PH_PROG);
  assign inLoad = (phase == PH_LOAD);
endmodule

// File: rtl/pgw_datapath.sv
module pgw_datapath
  import pgw_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int OFF_W       = 6,
  parameter int STORE_PAGES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic              pageMatch,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive,
  output logic [(1<<OFF_W)-1:0] validMask
);
  localparam int SLOTS       = 1 << OFF_W;
  localparam int PAGE_W      = ADDR_W - OFF_W;
  localparam int PG_IDX_W    = $clog2(STORE_PAGES);
  localparam int STORE_AW    = PG_IDX_W + OFF_W;
  localparam int STORE_BYTES = 1 << STORE_AW;

  logic [DATA_W-1:0] pageBuf [SLOTS];
  logic [DATA_W-1:0] storeMem [STORE_BYTES];
  logic [PAGE_W-1:0] pageReg;
  logic              lastTopBit;
  logic              togBit;
  logic [OFF_W-1:0]  slotSel;
  logic [STORE_AW-1:0] rdIdx;

  assign slotSel   = addr[OFF_W-1:0];
  assign pageMatch = (addr[ADDR_W-1:OFF_W] == pageReg);
  assign rdIdx     = {addr[OFF_W+PG_IDX_W-1:OFF_W], slotSel};

  always_ff @(posedge clk) begin
    if (strobes.loadByte) pageBuf[slotSel] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageReg    <= '0;
      validMask  <= '0;
      lastTopBit <= 1'b0;
      togBit     <= 1'b0;
    end else begin
      if (strobes.latchPage) pageReg <= addr[ADDR_W-1:OFF_W];
      if (strobes.loadByte) begin
        validMask[slotSel] <= 1'b1;
        lastTopBit         <= wrData[DATA_W-1];
      end
      if (strobes.readAcc && strobes.polling) togBit <= ~togBit;
      if (strobes.commitPage) begin
        validMask <= '0;
        togBit    <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STORE_BYTES; i++) storeMem[i] <= '1;
    end else if (strobes.commitPage) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (validMask[i])
          storeMem[{pageReg[PG_IDX_W-1:0], OFF_W'(i)}] <= pageBuf[i];
      end
    end
  end

  always_comb begin
    rdDrive = strobes.readAcc;
    if (!strobes.readAcc)
      rdData = '0;
    else if (strobes.polling)
      rdData = {~lastTopBit, togBit, {(DATA_W-2){1'b0}}};
    else
      rdData = storeMem[rdIdx];
  end
endmodule

// File: rtl/page_program_engine.sv
module page_program_engine
  import pgw_pkg::*;
#(
  parameter int LOAD_CYCLES = 4,
  parameter int PROG_CYCLES = 12,
  parameter int STORE_PAGES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        oeN,
  input  logic        weN,
  input  logic [14:0] addr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic        rdDrive,
  output logic        busy
);
  localparam int OFF_W = 6;

  ctrlStrobes_t strobes;
  logic pageMatch;
  logic inLoad;
  logic [(1<<OFF_W)-1:0] validMask;

  pgw_ctrl #(.LOAD_CYCLES(LOAD_CYCLES), .PROG_CYCLES(PROG_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .pageMatch(pageMatch), .strobes(strobes), .busy(busy), .inLoad(inLoad)
  );

  pgw_datapath #(.ADDR_W(15), .DATA_W(8), .OFF_W(OFF_W), .STORE_PAGES(STORE_PAGES)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addr(addr), .wrData(wrData),
    .pageMatch(pageMatch), .rdData(rdData), .rdDrive(rdDrive), .validMask(validMask)
  );
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        inLoad,
  input logic        rdDrive,
  input logic [7:0]  rdData,
  input logic [63:0] validMask
);
  // R4: the program phase is only ever entered from an open load window
  a_r4_prog_after_load: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(inLoad));

  // R5: the loaded-slot flags are empty once programming ends
  a_r5_mask_cleared: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (validMask == 64'd0));

  // R6: an undriven output carries zero
  a_r6_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !rdDrive |-> (rdData == 8'h00));

  // R7: the low status bits are zero while the program phase runs
  a_r7_status_low_bits: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rdDrive) |-> (rdData[5:0] == 6'd0));

  // R8: back-to-back status reads alternate bit 6
  a_r8_toggle_flips: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rdDrive && $past(busy && rdDrive)) |-> (rdData[6] != $past(rdData[6])));
endmodule

bind page_program_engine pgw_checker chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .inLoad(inLoad),
  .rdDrive(rdDrive), .rdData(rdData), .validMask(validMask)
);

// File: tb/page_program_engine_tb_top.sv
module page_program_engine_tb_top;
  localparam int LOADC = 4;
  localparam int PROGC = 12;
  localparam int PAGES = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic rdDrive, busy;

  int nChecks = 0;
  int nFails = 0;

  // behavioural reference state
  int  mState = 0;          // 0 idle, 1 loading, 2 programming
  int  mIdle = 0, mProg = 0, mPage = 0;
  byte mBuf [64];
  bit  mValid [64];
  byte mStore [int];
  bit  mLast7 = 0, mTog = 0;

  always #10 clk = ~clk;

  page_program_engine #(.LOAD_CYCLES(LOADC), .PROG_CYCLES(PROGC), .STORE_PAGES(PAGES)) dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdDrive(rdDrive), .busy(busy)
  );

  function automatic int storeIdx(input int a);
    return (((a >> 6) % PAGES) * 64) + (a & 63);
  endfunction

  function automatic logic [7:0] storeRead(input int a);
    int i = storeIdx(a);
    return mStore.exists(i) ? 8'(mStore[i]) : 8'hFF;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one bus cycle: drive after the falling edge, compare, advance the model at the rising edge
  task automatic step(input logic c, input logic o, input logic w,
                      input logic [14:0] a, input logic [7:0] d, input string tag);
    logic rd, wr, acc;
    logic [7:0] expData;
    ceN = c; oeN = o; weN = w; addr = a; wrData = d;
    #5;
    rd = !c && !o && w;
    wr = !c && !w && o;
    if (!rd) expData = 8'h00;
    else if (mState != 0) expData = {~mLast7, mTog, 6'd0};
    else expData = storeRead(int'(a));
    check(tag, rdData, expData, "rdData");
    check(tag, {7'd0, rdDrive}, {7'd0, rd}, "rdDrive");
    check(tag, {7'd0, busy}, {7'd0, logic'(mState == 2)}, "busy");
    acc = wr && ((mState == 0) || (mState == 1 && int'(a >> 6) == mPage));
    if (rd && mState != 0) mTog = ~mTog;
    case (mState)
      0: if (acc) begin mState = 1; mIdle = 0; mPage = int'(a >> 6); end
      1: if (acc) mIdle = 0;
         else if (mIdle == LOADC - 1) begin mState = 2; mProg = 0; end
         else mIdle++;
      default: if (mProg == PROGC - 1) begin
                 for (int i = 0; i < 64; i++)
                   if (mValid[i]) mStore[((mPage % PAGES) * 64) + i] = mBuf[i];
                 for (int i = 0; i < 64; i++) mValid[i] = 0;
                 mTog = 0;
                 mState = 0;
               end else mProg++;
    endcase
    if (acc) begin
      mBuf[a & 63] = byte'(d);
      mValid[a & 63] = 1;
      mLast7 = d[7];
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d, input string tag);
    step(1'b0, 1'b1, 1'b0, a, d, tag);
  endtask

  task automatic rd(input logic [14:0] a, input string tag);
    step(1'b0, 1'b0, 1'b1, a, 8'h00, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b1, 15'd0, 8'h00, tag);
  endtask

  task automatic waitDone(input string tag);
    for (int i = 0; i < 200 && mState != 0; i++) rd(15'd0, tag);
    idle(1, tag);
  endtask

  initial begin
    #4_000_000;
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mValid[i] = 0; mBuf[i] = 0; end
    @(negedge clk); @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    // reset state: quiet bus, not busy, erased array (R6, R10)
    idle(1, "R6");
    rd(15'h0045, "R10");

    // single byte, status polling while the window is open and during programming (R1, R7, R8)
    wr(15'h0045, 8'hA5, "R1");
    rd(15'h0045, "R7");
    rd(15'h0045, "R8");
    rd(15'h0011, "R8");
    waitDone("R4");
    rd(15'h0045, "R10");
    rd(15'h0044, "R5");

    // out of order, rewrite, gap just under the limit, foreign page ignored (R2, R3, R4)
    wr(15'h0183, 8'h11, "R2");
    idle(2, "R4");
    wr(15'h0180, 8'h22, "R2");
    wr(15'h0183, 8'h33, "R2");
    idle(LOADC - 1, "R4");
    wr(15'h01BF, 8'h44, "R2");
    wr(15'h0281, 8'h55, "R3");
    idle(LOADC - 1, "R3");
    rd(15'h0000, "R7");
    waitDone("R4");
    rd(15'h0180, "R2");
    rd(15'h0183, "R2");
    rd(15'h01BF, "R5");
    rd(15'h0181, "R5");
    rd(15'h0281, "R3");

    // strobes while programming change nothing (R9)
    wr(15'h0400, 8'h77, "R9");
    idle(LOADC, "R4");
    wr(15'h0401, 8'h88, "R9");
    wr(15'h0400, 8'h01, "R9");
    rd(15'h0400, "R9");
    waitDone("R9");
    rd(15'h0400, "R9");
    rd(15'h0401, "R9");

    // full page in descending slot order (R2, R5)
    for (int i = 63; i >= 0; i--) wr(15'((5 << 6) | i), 8'(i ^ 8'h5A), "R2");
    waitDone("R5");
    for (int i = 0; i < 64; i++) rd(15'((5 << 6) | i), "R5");

    // bus decode corners: no drive, no write (R1, R6)
    step(1'b0, 1'b1, 1'b1, 15'h0045, 8'h00, "R6");
    step(1'b1, 1'b0, 1'b1, 15'h0045, 8'h00, "R6");
    step(1'b0, 1'b0, 1'b0, 15'h0045, 8'h12, "R1");
    step(1'b1, 1'b1, 1'b0, 15'h0045, 8'h34, "R1");
    idle(LOADC + 2, "R1");
    rd(15'h0045, "R1");

    // page index wraps into the array; toggle restarts at 0 in a new cycle (R5, R8, R10)
    wr(15'((PAGES + 1) << 6 | 3), 8'h6C, "R10");
    rd(15'h0000, "R8");
    rd(15'h0000, "R8");
    waitDone("R8");
    rd(15'h0043, "R5");
    rd(15'((PAGES + 1) << 6 | 3), "R5");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule